// File: doc/BRIEF.md
# Chunked Sector Write Accumulator

This block sits between a host command channel and a flash sector writer. The host sends firmware payload in short data frames. Each frame holds a command byte, a length byte and at most 252 data bytes. The block packs those bytes, in arrival order, into one sector buffer. It also holds a 16-bit sector sequence number that the host can set. That number gives the flash start address of the sector, so an interrupted image transfer can resume at any sector.

When the buffer holds a whole sector, the host sends a block-check frame carrying a 64-bit checksum. The block then raises a write request toward a downstream writer. The request carries the sector address and the checksum. The writer reads the buffer through a read port and answers with one of four result codes. The block reports its progress in an 8-bit status value that the host reads after every frame. The sector size is a parameter. The default is reduced to 1024 bytes; the nominal size is 64 KB.

Top module: `sector_chunk_accum`

## Requirements
- R1: After reset, status is 0xFF, wr_req is 0 and wr_addr equals START_OFFSET (0).
- R2: A frame of command 0x47, a length byte L with 1 <= L <= 252, and then L data bytes stores the data bytes at consecutive buffer positions starting at the current fill position. The fill position advances by L and status becomes 0x01 after the last byte. A length of 0 gives status 0x01 and stores nothing.
- R3: A 0x47 frame is rejected with status 0x02 if L > 252 or if fill + L exceeds SECTOR_BYTES. No byte of a rejected frame is stored and the fill position does not change. The fill position never exceeds SECTOR_BYTES.
- R4: A frame of command 0x49 followed by two bytes (low byte, then high byte) loads the sequence number and sets status 0x01. wr_addr is always START_OFFSET + sequence × SECTOR_BYTES.
- R5: A frame of command 0x48 followed by 8 checksum bytes (least significant byte first), sent while the buffer is full, sets status 0x20 and raises wr_req. wr_crc then holds the checksum. wr_req stays high until a result arrives. If the buffer is not full, the same frame gives status 0x02 and raises no request.
- R6: While wr_req is high, any 0x47, 0x48 or 0x49 frame is refused with status 0x10. A refused frame changes neither the buffer, the sequence number nor wr_crc.
- R7: A result with res_valid high while wr_req is high drops wr_req on the next cycle and clears the fill position. The result code maps to a status: code 0 gives 0x01 and also increments the sequence number, wrapping modulo 2^16. Code 1 (checksum mismatch, resend) gives 0x21, code 2 (write failure) gives 0x05 and code 3 (erase failure) gives 0x04. Codes 1 to 3 leave the sequence number unchanged.
- R8: A frame whose command byte is anything other than 0x47, 0x48 or 0x49 gives status 0x03. The rest of that frame is ignored.
- R9: rd_data presents the buffer byte at rd_addr one clock after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | A host byte is present this cycle |
| host_first | input | 1 | The host byte is a command byte that starts a frame |
| host_byte | input | 8 | Host byte |
| status | output | 8 | Progress and result status |
| wr_req | output | 1 | Sector write request to the writer |
| wr_addr | output | ADDR_W | Flash start address of the current sector |
| wr_crc | output | 64 | Checksum taken from the last accepted block-check frame |
| rd_addr | input | log2(SECTOR_BYTES) | Buffer read address from the writer |
| rd_data | output | 8 | Buffer byte, registered |
| res_valid | input | 1 | Writer result strobe |
| res_code | input | 2 | 0 ok, 1 checksum mismatch, 2 write fail, 3 erase fail |

## Verification
The hardest states to reach are the exact-fit and one-over boundaries of the sector. Because chunks of up to 252 bytes do not divide the sector, the final chunk is only a few bytes long. The stimulus fills each sector with random chunk lengths drawn from a fixed seed. When the remaining room is small, it sometimes offers a chunk one byte too long before the exact-fit chunk, and it reads the whole buffer back to confirm that the rejected bytes were never stored. The fill reset after every failure result is confirmed the same way: the next sector is read back from position zero. Sequence wrap-around is reached by loading 0xFFFF and then completing a successful write.

// File: rtl/sca_pkg.sv
package sca_pkg;
    localparam logic [7:0] CMD_DATA  = 8'h47;
    localparam logic [7:0] CMD_CHECK = 8'h48;
    localparam logic [7:0] CMD_SEQ   = 8'h49;

    localparam logic [7:0] ST_NONE       = 8'hFF;
    localparam logic [7:0] ST_OK         = 8'h01;
    localparam logic [7:0] ST_REJECT     = 8'h02;
    localparam logic [7:0] ST_UNSUP      = 8'h03;
    localparam logic [7:0] ST_ERASE_FAIL = 8'h04;
    localparam logic [7:0] ST_WRITE_FAIL = 8'h05;
    localparam logic [7:0] ST_DATA_BUSY  = 8'h10;
    localparam logic [7:0] ST_CHECK_BUSY = 8'h20;
    localparam logic [7:0] ST_RESEND     = 8'h21;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_CRC   = 2'd1;
    localparam logic [1:0] RES_WRITE = 2'd2;
    localparam logic [1:0] RES_ERASE = 2'd3;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_LEN,
        PS_DATA,
        PS_CRC,
        PS_SEQ,
        PS_DROP
    } pstate_e;
endpackage

// File: rtl/sca_sector_buf.sv
module sca_sector_buf #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sca_addr_gen.sv
module sca_addr_gen #(
    parameter int                SEQ_W        = 16,
    parameter int                SHIFT        = 10,
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] START_OFFSET = '0
) (
    input  logic [SEQ_W-1:0]  seq,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = START_OFFSET + (ADDR_W'(seq) << SHIFT);
    end
endmodule

// File: rtl/sca_result_map.sv
module sca_result_map
    import sca_pkg::*;
(
    input  logic [1:0] code,
    output logic [7:0] stat,
    output logic       ok
);
    always_comb begin
        ok = 1'b0;
        unique case (code)
            RES_OK:    begin stat = ST_OK; ok = 1'b1; end
            RES_CRC:   stat = ST_RESEND;
            RES_WRITE: stat = ST_WRITE_FAIL;
            default:   stat = ST_ERASE_FAIL;
        endcase
    end
endmodule

// File: rtl/sector_chunk_accum.sv
module sector_chunk_accum
    import sca_pkg::*;
#(
    parameter int                SECTOR_BYTES = 1024,
    parameter int                CHUNK_MAX    = 252,
    parameter int                SEQ_W        = 16,
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] START_OFFSET = '0,
    parameter int                CRC_BYTES    = 8,
    localparam int               LOG2         = $clog2(SECTOR_BYTES),
    localparam int               CRC_W        = 8 * CRC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_first,
    input  logic [7:0]        host_byte,
    output logic [7:0]        status,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CRC_W-1:0]  wr_crc,
    input  logic [LOG2-1:0]   rd_addr,
    output logic [7:0]        rd_data,
    input  logic              res_valid,
    input  logic [1:0]        res_code
);
    localparam int FILL_W = LOG2 + 1;
    localparam int CNT_W  = (CRC_BYTES > 2) ? $clog2(CRC_BYTES) : 1;
    localparam int SUM_W  = ((FILL_W > 8) ? FILL_W : 8) + 1;

    typedef struct packed {
        pstate_e          pst;
        logic [7:0]       rem;
        logic [CNT_W-1:0] cnt;
        logic [FILL_W-1:0] fill;
        logic [SEQ_W-1:0] seq;
        logic [7:0]       seq_lo;
        logic [CRC_W-1:0] crc;
        logic             busy;
        logic [7:0]       stat;
    } regs_t;

    regs_t r_d, r_q;

    logic            buf_we;
    logic [LOG2-1:0] buf_waddr;
    logic [7:0]      res_stat;
    logic            res_ok;
    logic [SUM_W-1:0] room_sum;
    logic [FILL_W-1:0] fill_q;

    sca_result_map u_map (
        .code (res_code),
        .stat (res_stat),
        .ok   (res_ok)
    );

    always_comb begin
        r_d       = r_q;
        buf_we    = 1'b0;
        buf_waddr = r_q.fill[LOG2-1:0];
        room_sum  = SUM_W'(r_q.fill) + SUM_W'(host_byte);

        if (host_valid && host_first) begin
            r_d.cnt = '0;
            unique case (host_byte)
                CMD_DATA: begin
                    if (r_q.busy) begin
                        r_d.stat = ST_DATA_BUSY;
                        r_d.pst  = PS_DROP;
                    end else begin
                        r_d.pst = PS_LEN;
                    end
                end
                CMD_CHECK: begin
                    if (r_q.busy) begin
                        r_d.stat = ST_DATA_BUSY;
                        r_d.pst  = PS_DROP;
                    end else if (r_q.fill != FILL_W'(SECTOR_BYTES)) begin
                        r_d.stat = ST_REJECT;
                        r_d.pst  = PS_DROP;
                    end else begin
                        r_d.pst = PS_CRC;
                    end
                end
                CMD_SEQ: begin
                    if (r_q.busy) begin
                        r_d.stat = ST_DATA_BUSY;
                        r_d.pst  = PS_DROP;
                    end else begin
                        r_d.pst = PS_SEQ;
                    end
                end
                default: begin
                    r_d.stat = ST_UNSUP;
                    r_d.pst  = PS_DROP;
                end
            endcase
        end else if (host_valid) begin
            unique case (r_q.pst)
                PS_LEN: begin
                    if ((32'(host_byte) > CHUNK_MAX) ||
                        (room_sum > SUM_W'(SECTOR_BYTES))) begin
                        r_d.stat = ST_REJECT;
                        r_d.pst  = PS_DROP;
                    end else if (host_byte == 8'd0) begin
                        r_d.stat = ST_OK;
                        r_d.pst  = PS_IDLE;
                    end else begin
                        r_d.rem = host_byte;
                        r_d.pst = PS_DATA;
                    end
                end
                PS_DATA: begin
                    buf_we   = 1'b1;
                    r_d.fill = r_q.fill + 1'b1;
                    r_d.rem  = r_q.rem - 8'd1;
                    if (r_q.rem == 8'd1) begin
                        r_d.stat = ST_OK;
                        r_d.pst  = PS_IDLE;
                    end
                end
                PS_CRC: begin
                    r_d.crc[8*r_q.cnt +: 8] = host_byte;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(CRC_BYTES - 1)) begin
                        r_d.busy = 1'b1;
                        r_d.stat = ST_CHECK_BUSY;
                        r_d.pst  = PS_IDLE;
                    end
                end
                PS_SEQ: begin
                    if (r_q.cnt == '0) begin
                        r_d.seq_lo = host_byte;
                        r_d.cnt    = CNT_W'(1);
                    end else begin
                        r_d.seq  = SEQ_W'({host_byte, r_q.seq_lo});
                        r_d.stat = ST_OK;
                        r_d.pst  = PS_IDLE;
                    end
                end
                default: begin
                    r_d.pst = r_q.pst;
                end
            endcase
        end

        if (r_q.busy && res_valid) begin
            r_d.busy = 1'b0;
            r_d.fill = '0;
            r_d.stat = res_stat;
            if (res_ok) begin
                r_d.seq = r_q.seq + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.pst  <= PS_IDLE;
            r_q.stat <= ST_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    sca_sector_buf #(
        .DEPTH (SECTOR_BYTES),
        .AW    (LOG2)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (host_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    sca_addr_gen #(
        .SEQ_W        (SEQ_W),
        .SHIFT        (LOG2),
        .ADDR_W       (ADDR_W),
        .START_OFFSET (START_OFFSET)
    ) u_addr (
        .seq  (r_q.seq),
        .addr (wr_addr)
    );

    assign fill_q = r_q.fill;
    assign status = r_q.stat;
    assign wr_req = r_q.busy;
    assign wr_crc = r_q.crc;
endmodule

// File: rtl/sca_accum_chk.sv
module sca_accum_chk #(
    parameter int SECTOR_BYTES = 1024,
    parameter int ADDR_W       = 32,
    parameter int FILL_W       = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        status,
    input logic              res_valid,
    input logic [1:0]        res_code,
    input logic [FILL_W-1:0] fill
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(SECTOR_BYTES)); // R3

    AST_REQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> status == 8'h20); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !res_valid) |=> wr_req); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !res_valid) |=> $stable(wr_addr)); // R6

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && res_valid) |=> (!wr_req && fill == '0)); // R7

    AST_FAIL_KEEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && res_valid && res_code != 2'd0) |=> $stable(wr_addr)); // R7
endmodule

bind sector_chunk_accum sca_accum_chk #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .ADDR_W       (ADDR_W),
    .FILL_W       (LOG2 + 1)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .status    (status),
    .res_valid (res_valid),
    .res_code  (res_code),
    .fill      (fill_q)
);

// File: tb/sector_chunk_accum_tb_top.sv
module sector_chunk_accum_tb_top;
    localparam int SEC = 1024;
    localparam int AW  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_first = 1'b0;
    logic [7:0]  host_byte = 8'h00;
    logic [7:0]  status;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [63:0] wr_crc;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        res_valid = 1'b0;
    logic [1:0]  res_code = 2'd0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  model [SEC];
    int          exp_fill = 0;
    logic [15:0] exp_seq = 16'h0000;

    always #5 clk = ~clk;

    sector_chunk_accum dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_first (host_first),
        .host_byte  (host_byte),
        .status     (status),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_crc     (wr_crc),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .res_valid  (res_valid),
        .res_code   (res_code)
    );

    function automatic logic [31:0] exp_addr(input logic [15:0] s);
        return 32'(s) * 32'(SEC);
    endfunction

    function automatic logic [7:0] exp_res(input logic [1:0] c);
        case (c)
            2'd0: return 8'h01;
            2'd1: return 8'h21;
            2'd2: return 8'h05;
            default: return 8'h04;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hb(input bit f, input logic [7:0] b);
        host_valid = 1'b1;
        host_first = f;
        host_byte  = b;
        @(negedge clk);
        host_valid = 1'b0;
        host_first = 1'b0;
    endtask

    task automatic send_chunk(input int len, input bit accept, input logic [7:0] want);
        hb(1'b1, 8'h47);
        hb(1'b0, 8'(len));
        if (accept) begin
            for (int i = 0; i < len; i++) begin
                logic [7:0] b = 8'($urandom);
                model[exp_fill] = b;
                exp_fill++;
                hb(1'b0, b);
            end
        end else begin
            for (int i = 0; i < 3; i++) hb(1'b0, 8'($urandom));
        end
        chk("R2/R3/R6 chunk status", 64'(status), 64'(want));
    endtask

    task automatic send_seq(input logic [15:0] v);
        hb(1'b1, 8'h49);
        hb(1'b0, v[7:0]);
        hb(1'b0, v[15:8]);
    endtask

    task automatic send_check(input logic [63:0] c);
        hb(1'b1, 8'h48);
        for (int k = 0; k < 8; k++) hb(1'b0, c[8*k +: 8]);
    endtask

    task automatic result(input logic [1:0] c);
        res_valid = 1'b1;
        res_code  = c;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic fill_sector();
        while (exp_fill < SEC) begin
            int room = SEC - exp_fill;
            int len  = int'($urandom % 252) + 1;
            if (($urandom % 4) == 0) begin
                if (room < 252) send_chunk(room + 1, 1'b0, 8'h02); // R3 overflow
                else send_chunk(253 + int'($urandom % 3), 1'b0, 8'h02); // R3 length
            end
            if (len > room) len = room;
            send_chunk(len, 1'b1, 8'h01); // R2
        end
    endtask

    task automatic readback();
        int bad = 0;
        for (int a = 0; a < SEC; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            if (rd_data !== model[a]) begin
                bad++;
                if (bad < 4) chk("R9 buffer byte", 64'(rd_data), 64'(model[a]));
            end
        end
        chk("R2/R3/R9 buffer mismatches", 64'(bad), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] crc;
        logic [1:0]  codes [3];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", 64'(status), 64'hFF);
        chk("R1 wr_req", 64'(wr_req), 64'd0);
        chk("R1 wr_addr", 64'(wr_addr), 64'd0);

        hb(1'b1, 8'h30); hb(1'b0, 8'h11);
        chk("R8 unknown command", 64'(status), 64'h03);

        send_seq(16'h1234); exp_seq = 16'h1234;
        chk("R4 seq status", 64'(status), 64'h01);
        chk("R4 address", 64'(wr_addr), 64'(exp_addr(exp_seq)));

        send_check(64'h1);
        chk("R5 check on partial buffer", 64'(status), 64'h02);
        chk("R5 no request on partial", 64'(wr_req), 64'd0);

        send_chunk(253, 1'b0, 8'h02); // R3
        send_chunk(0, 1'b1, 8'h01);   // R2 zero length
        fill_sector();
        readback();

        crc = {$urandom, $urandom};
        send_check(crc);
        chk("R5 check status", 64'(status), 64'h20);
        chk("R5 wr_req", 64'(wr_req), 64'd1);
        chk("R5 wr_crc", wr_crc, crc);

        send_chunk(4, 1'b0, 8'h10); // R6
        send_seq(16'h0005);
        chk("R6 seq refused", 64'(status), 64'h10);
        chk("R6 address kept", 64'(wr_addr), 64'(exp_addr(exp_seq)));
        send_check(~crc);
        chk("R6 check refused", 64'(status), 64'h10);
        chk("R6 crc kept", wr_crc, crc);
        readback(); // R6 buffer untouched

        result(2'd1);
        exp_fill = 0;
        chk("R7 resend status", 64'(status), 64'h21);
        chk("R7 wr_req drop", 64'(wr_req), 64'd0);
        chk("R7 seq kept on fail", 64'(wr_addr), 64'(exp_addr(exp_seq)));

        codes[0] = 2'd2; codes[1] = 2'd3; codes[2] = 2'd0;
        for (int n = 0; n < 3; n++) begin
            fill_sector();
            readback(); // R7 fill restarted at 0
            crc = {$urandom, $urandom};
            send_check(crc);
            chk("R5 check status", 64'(status), 64'h20);
            result(codes[n]);
            if (codes[n] == 2'd0) exp_seq = exp_seq + 16'd1;
            exp_fill = 0;
            chk("R7 result status", 64'(status), 64'(exp_res(codes[n])));
            chk("R7 address after result", 64'(wr_addr), 64'(exp_addr(exp_seq)));
        end

        send_seq(16'hFFFF); exp_seq = 16'hFFFF;
        chk("R4 top address", 64'(wr_addr), 64'(exp_addr(exp_seq)));
        fill_sector();
        send_check(64'hA5);
        result(2'd0);
        exp_seq = 16'h0000;
        exp_fill = 0;
        chk("R7 wrap status", 64'(status), 64'h01);
        chk("R7 wrap address", 64'(wr_addr), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule